// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block moves an 18-bit word between two shared ports, A and B, with one independent storage path for each direction. A single storage element per bit can act as a transparent latch, a closed latch, an edge-triggered register, or an edge-triggered register with a clock enable.

Each direction has its own set of four controls:
- a latch enable;
- a data clock;
- an active-low clock enable;
- an active-low output enable.

When its output enable is deasserted, a direction releases its destination port to high impedance. Both ports are modelled as tri-state nets. Keeping the two directions from driving the same wires at the same time is the user's responsibility.

The block runs on one system clock with a synchronous active-high reset. Each direction's data clock is sampled on that system clock. A low-to-high change seen between two system edges counts as a data-clock edge.

The latch enable has priority over the clock. While it is high, the destination port follows the source combinationally, and the storage tracks the source on every system edge. The last tracked value therefore stays valid when the latch closes.

Top module: `ubr_top`

## Requirements
- R1: While `ab_le` is 1 and `ab_oe_n` is 0, `b_port` equals `a_port` in the same cycle, with no clock edge needed.
- R2: When `ab_le` falls and no data-clock capture happens in that system cycle, `b_port` keeps the `a_port` value sampled at the last system edge while `ab_le` was 1, whatever `a_port` does afterwards.
- R3: With `ab_le` 0 and `ab_cken_n` 0, a system edge that sees `ab_clk` at 1 after seeing it at 0 on the previous edge stores `a_port`. From then on, `b_port` shows that value.
- R4: With `ab_le` 0 and `ab_clk` held steady at 1 or at 0, the stored value is kept and `b_port` does not change, even when `a_port` changes.
- R5: With `ab_cken_n` 1, rising edges of `ab_clk` do not change the stored value.
- R6: When `ab_oe_n` is 1, the block does not drive `b_port`; when `ba_oe_n` is 1, it does not drive `a_port`. When either enable is 0, that direction drives its stored or transparent value.
- R7: The B-to-A direction behaves as in R1 to R5 using `ba_le`, `ba_clk`, `ba_cken_n` and `ba_oe_n`. Its activity leaves the A-to-B stored value unchanged.
- R8: If the latch enable falls in the same system cycle in which the data clock rises with its clock enable at 0, the source value present at that system edge is stored. This is the new value, not the one tracked while the latch was open.
- R9: Reset clears both stored values to 0. A data clock that is already 1 when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all storage and clock sampling use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_port | inout | 18 | A-side bus: source for A-to-B, destination for B-to-A |
| b_port | inout | 18 | B-side bus: destination for A-to-B, source for B-to-A |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B data clock, captures on its rising edge |
| ab_cken_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A data clock, captures on its rising edge |
| ba_cken_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Two functions can meet in one system cycle: closing the latch, and capturing on a data-clock edge. The bench provokes this by lowering the latch enable, raising the data clock and changing the source word at the same instant. It then expects the new word at the destination (R8). A second run repeats the same moves with the clock enable held inactive, and there the tracked old word must survive (R2). Reset meets a data clock that is already high in the same way: the first system edge after reset must not count as a capture.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

    // What a storage element does at the next system edge
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_FOLLOW  = 2'd1,
        OP_CAPTURE = 2'd2
    } store_op_e;

    // Per-direction control bundle
    typedef struct packed {
        logic le;      // latch enable, 1 = transparent
        logic ck;      // data clock as seen on the pins
        logic cken_n;  // clock enable, active low
        logic oe_n;    // output enable, active low
    } dir_ctl_t;

    // Latch enable outranks the gated clock edge
    function automatic store_op_e pick_op(input logic le,
                                          input logic rise,
                                          input logic cken_n);
        if (le)
            return OP_FOLLOW;
        else if (rise && !cken_n)
            return OP_CAPTURE;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ubr_edge.sv
module ubr_edge (
    input  logic clk,
    input  logic rst,
    input  logic ck_in,
    output logic rise
);
    logic prev_q;

    // Reset treats the data clock as already high, so a clock that is
    // high when reset ends is not mistaken for an edge.
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b1;
        else
            prev_q <= ck_in;
    end

    assign rise = ck_in & ~prev_q;
endmodule

// File: rtl/ubr_lane.sv
module ubr_lane
    import ubr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive_en
);
    logic         rise;
    store_op_e    op;
    logic [W-1:0] store_q;

    ubr_edge i_edge (
        .clk   (clk),
        .rst   (rst),
        .ck_in (ctl.ck),
        .rise  (rise)
    );

    assign op = pick_op(ctl.le, rise, ctl.cken_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            case (op)
                OP_FOLLOW,
                OP_CAPTURE: store_q <= din;
                default:    store_q <= store_q;
            endcase
        end
    end

    // Transparent path bypasses storage while the latch is open
    assign dout     = ctl.le ? din : store_q;
    assign drive_en = ~ctl.oe_n;
endmodule

// File: rtl/ubr_pad.sv
module ubr_pad #(
    parameter int W = 18
) (
    inout  wire  [W-1:0] pad,
    input  logic [W-1:0] val,
    input  logic         en
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pad[i] = en ? val[i] : 1'bz;
    end
endmodule

// File: rtl/ubr_top.sv
module ubr_top
    import ubr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    inout  wire  [W-1:0] a_port,
    inout  wire  [W-1:0] b_port,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_cken_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_cken_n,
    input  logic         ba_oe_n
);
    dir_ctl_t     ab_ctl, ba_ctl;
    logic [W-1:0] ab_val, ba_val;
    logic         ab_en, ba_en;

    assign ab_ctl = {ab_le, ab_clk, ab_cken_n, ab_oe_n};
    assign ba_ctl = {ba_le, ba_clk, ba_cken_n, ba_oe_n};

    ubr_lane #(.W(W)) i_lane_ab (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ab_ctl),
        .din      (a_port),
        .dout     (ab_val),
        .drive_en (ab_en)
    );

    ubr_lane #(.W(W)) i_lane_ba (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ba_ctl),
        .din      (b_port),
        .dout     (ba_val),
        .drive_en (ba_en)
    );

    ubr_pad #(.W(W)) i_pad_b (
        .pad (b_port),
        .val (ab_val),
        .en  (ab_en)
    );

    ubr_pad #(.W(W)) i_pad_a (
        .pad (a_port),
        .val (ba_val),
        .en  (ba_en)
    );
endmodule

// File: rtl/ubr_top_chk.sv
module ubr_top_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_port,
    input logic [W-1:0] b_port,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_cken_n,
    input logic         ab_oe_n,
    input logic         ba_le,
    input logic         ba_clk,
    input logic         ba_cken_n,
    input logic         ba_oe_n,
    input logic [W-1:0] ab_val,
    input logic [W-1:0] ba_val
);
    // R1: open latch passes the A word straight through
    p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> ab_val == a_port);

    // R3: gated rising data-clock edge stores the A word
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ab_le && !ab_cken_n && ab_clk && !$past(ab_clk))
        |=> (ab_le || ab_val == $past(a_port)));

    // R4, R5: no qualified edge means the stored word stays put
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && (ab_cken_n || !ab_clk || $past(ab_clk) || $past(rst)))
        |=> (ab_le || $stable(ab_val)));

    // R6: an enabled direction drives its value onto the far port
    p_drive_b_r6: assert property (@(posedge clk) disable iff (rst)
        !ab_oe_n |-> b_port == ab_val);

    // R7: mirror direction, capture and drive
    p_capture_ba_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ba_le && !ba_cken_n && ba_clk && !$past(ba_clk))
        |=> (ba_le || ba_val == $past(b_port)));

    p_drive_a_r7: assert property (@(posedge clk) disable iff (rst)
        !ba_oe_n |-> a_port == ba_val);
endmodule

bind ubr_top ubr_top_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .a_port    (a_port),
    .b_port    (b_port),
    .ab_le     (ab_le),
    .ab_clk    (ab_clk),
    .ab_cken_n (ab_cken_n),
    .ab_oe_n   (ab_oe_n),
    .ba_le     (ba_le),
    .ba_clk    (ba_clk),
    .ba_cken_n (ba_cken_n),
    .ba_oe_n   (ba_oe_n),
    .ab_val    (ab_val),
    .ba_val    (ba_val)
);

// File: tb/test_ubr_top.sv
module test_ubr_top;
    localparam int W      = 18;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ab_le = 1'b0, ab_clk = 1'b0, ab_cken_n = 1'b0, ab_oe_n = 1'b1;
    logic ba_le = 1'b0, ba_clk = 1'b0, ba_cken_n = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] a_drv = '0, b_drv = '0;
    logic a_en = 1'b0, b_en = 1'b0;
    wire  [W-1:0] a_port, b_port;
    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    assign a_port = a_en ? a_drv : 'z;
    assign b_port = b_en ? b_drv : 'z;

    always #(CLK_NS/2) clk = ~clk;

    ubr_top #(.W(W)) i_ubr_top (
        .clk(clk), .rst(rst), .a_port(a_port), .b_port(b_port),
        .ab_le(ab_le), .ab_clk(ab_clk), .ab_cken_n(ab_cken_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_clk(ba_clk), .ba_cken_n(ba_cken_n), .ba_oe_n(ba_oe_n)
    );

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        ab_clk = 1'b1; ab_cken_n = 1'b0; ab_le = 1'b0; ab_oe_n = 1'b0;
        a_en = 1'b1; a_drv = '1;
        repeat (3) step();
        rst = 1'b0;
        #1 check("R9 cleared after reset", b_port, '0);
        step();
        check("R9 high clock at reset not an edge", b_port, '0);
        ab_clk = 1'b0;
        step();
    endtask

    task automatic t_transparent();
        ab_le = 1'b1; a_drv = 18'h2A5A5;
        #1 check("R1 follow first word", b_port, 18'h2A5A5);
        a_drv = 18'h15A5A;
        #1 check("R1 follow second word", b_port, 18'h15A5A);
        step();
        check("R1 follow after edge", b_port, 18'h15A5A);
    endtask

    task automatic t_latch_close();
        ab_le = 1'b1; a_drv = 18'h0F0F0;
        step();
        ab_le = 1'b0; a_drv = 18'h3C3C3;
        #1 check("R2 closed latch keeps word", b_port, 18'h0F0F0);
        step();
        check("R2 still kept after edge", b_port, 18'h0F0F0);
    endtask

    task automatic t_capture();
        ab_cken_n = 1'b0; a_drv = 18'h12345;
        ab_clk = 1'b1;
        step();
        check("R3 rising clock captures", b_port, 18'h12345);
        a_drv = 18'h2BCDE;
        step();
        check("R4 clock held high keeps", b_port, 18'h12345);
        ab_clk = 1'b0;
        step();
        check("R4 clock held low keeps", b_port, 18'h12345);
    endtask

    task automatic t_cken();
        ab_cken_n = 1'b1; a_drv = 18'h3FFFF;
        ab_clk = 1'b1; step();
        ab_clk = 1'b0; step();
        check("R5 disabled edge ignored", b_port, 18'h12345);
        ab_cken_n = 1'b0; ab_clk = 1'b1; step();
        check("R3 enabled edge captures", b_port, 18'h3FFFF);
        ab_clk = 1'b0; step();
    endtask

    task automatic t_oe();
        ab_oe_n = 1'b1; b_en = 1'b1; b_drv = '0;
        #1 check("R6 B side released", b_port, '0);
        b_en = 1'b0; ab_oe_n = 1'b0;
        #1 check("R6 B side driven again", b_port, 18'h3FFFF);
        step();
    endtask

    task automatic t_ba();
        ab_oe_n = 1'b1; a_en = 1'b0;
        ba_oe_n = 1'b0; b_en = 1'b1;
        ba_le = 1'b1; b_drv = 18'h0AAAA;
        #1 check("R7 B to A transparent", a_port, 18'h0AAAA);
        step();
        ba_le = 1'b0; b_drv = 18'h05555;
        step();
        check("R7 B to A closed latch", a_port, 18'h0AAAA);
        ba_clk = 1'b1; step();
        check("R7 B to A capture", a_port, 18'h05555);
        ba_clk = 1'b0;
        ba_oe_n = 1'b1; a_en = 1'b1; a_drv = '0;
        #1 check("R6 A side released", a_port, '0);
        b_en = 1'b0; ab_oe_n = 1'b0;
        #1 check("R7 A to B word untouched", b_port, 18'h3FFFF);
        step();
    endtask

    task automatic t_same_cycle();
        ab_le = 1'b1; a_drv = 18'h11111;
        step();
        ab_le = 1'b0; ab_clk = 1'b1; ab_cken_n = 1'b0; a_drv = 18'h22222;
        step();
        check("R8 close with edge takes new word", b_port, 18'h22222);
        ab_clk = 1'b0; ab_le = 1'b1; a_drv = 18'h11111;
        step();
        ab_le = 1'b0; ab_clk = 1'b1; ab_cken_n = 1'b1; a_drv = 18'h22222;
        step();
        check("R2 close with blocked edge keeps old", b_port, 18'h11111);
        ab_clk = 1'b0;
        step();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_transparent();
        t_latch_close();
        t_capture();
        t_cken();
        t_oe();
        t_ba();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule